// File: doc/BRIEF.md
# Staged Right Rotator and Shifter

This block moves an N-bit word to the right by a variable distance and writes the result to an output register one clock later. The distance is set by a log2(N)-bit amount. The word passes through log2(N) fixed stages that move it by 1, 2, 4, ... positions. A stage acts only when its bit of the amount is set, and otherwise passes the word through unchanged. Each stage is a row of two-input multiplexers, one per bit. No stage indexes by a variable.

A 2-bit mode input decides what enters the vacated high positions:
- The bits that leave the low end, so the word is rotated.
- Zeros, for an unsigned divide by a power of two.
- Copies of the original top bit, for a signed divide.

The block is used wherever a datapath needs a rotate or a right shift and can accept one register stage.

Top module: `log_shifter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the output register is cleared, so `dout` reads all zeros after that edge whatever the other inputs are.
- R2: `dout` shows the result for the `din`, `amt` and `mode` values sampled at the previous rising edge, a latency of exactly one cycle.
- R3: An amount of 0 gives `dout` equal to `din` in every mode.
- R4: With `mode` = 2'b00 the result is `din` rotated right by `amt`. Bit i of the result is `din[(i+amt) mod N]`.
- R5: With `mode` = 2'b01 the result is `din` shifted right by `amt`, and the `amt` highest bits are filled with 0.
- R6: With `mode` = 2'b10 the result is `din` shifted right by `amt`, and the `amt` highest bits are filled with `din[N-1]`. Two examples with N = 8:
  - 8'h80 by 1 gives 8'hC0.
  - 8'h92 by 3 gives 8'hF2.
- R7: `mode` = 2'b11 produces exactly the rotate result of R4.
- R8: The largest amount, N-1, is honoured in every mode. For example, in logical mode with N = 8, 8'h80 by 7 gives 8'h01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | N | Word to be moved |
| amt | input | log2(N) | Distance to move right |
| mode | input | 2 | 00 rotate, 01 logical, 10 arithmetic, 11 rotate |
| dout | output | N | Registered result |

## Verification
The bench builds the block with the default N = 8. At this width every combination of the 256 data words, the 8 amounts and the 4 mode codes can be driven, which is 8192 vectors. Each one is compared with a result formed from plain shift operators. Because the sweep is exhaustive at N = 8, every stage is reached in both of its settings, as are every wrap and fill boundary, the duplicate rotate code, and sign fill with the top bit both set and clear.

// File: rtl/rsh_pkg.sv
package rsh_pkg;

  // Mode encodings applied on the mode port
  typedef enum logic [1:0] {
    SHM_ROT     = 2'b00,
    SHM_LSR     = 2'b01,
    SHM_ASR     = 2'b10,
    SHM_ROT_ALT = 2'b11
  } shm_e;

  // True when the mode wraps bits around instead of filling
  function automatic logic mode_wraps(input logic [1:0] m);
    return (m == SHM_ROT) || (m == SHM_ROT_ALT);
  endfunction

endpackage

// File: rtl/rsh_mode_dec.sv
module rsh_mode_dec #(
  parameter int N = 8
) (
  input  logic [1:0]   mode,
  input  logic [N-1:0] din,
  output logic         wrap,
  output logic         fill
);
  import rsh_pkg::*;

  always_comb begin
    wrap = mode_wraps(mode);
    unique case (mode)
      SHM_ASR: fill = din[N-1];
      default: fill = 1'b0;
    endcase
  end

endmodule

// File: rtl/rsh_stage.sv
module rsh_stage #(
  parameter int N    = 8,
  parameter int DIST = 1
) (
  input  logic         en,
  input  logic         wrap,
  input  logic         fill,
  input  logic [N-1:0] w_in,
  output logic [N-1:0] w_out
);

  // One two-input mux per bit; the source of the moved value is fixed
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic moved;
    if (i + DIST < N) begin : g_inner
      assign moved = w_in[i + DIST];
    end else begin : g_edge
      assign moved = wrap ? w_in[i + DIST - N] : fill;
    end
    assign w_out[i] = en ? moved : w_in[i];
  end

endmodule

// File: rtl/log_shifter.sv
module log_shifter #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         din,
  input  logic [$clog2(N)-1:0] amt,
  input  logic [1:0]           mode,
  output logic [N-1:0]         dout
);
  localparam int AW = $clog2(N);

  logic         wrap;
  logic         fill;
  logic [N-1:0] chain [0:AW];

  rsh_mode_dec #(.N(N)) u_dec (
    .mode (mode),
    .din  (din),
    .wrap (wrap),
    .fill (fill)
  );

  assign chain[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    rsh_stage #(.N(N), .DIST(1 << k)) u_stage (
      .en    (amt[k]),
      .wrap  (wrap),
      .fill  (fill),
      .w_in  (chain[k]),
      .w_out (chain[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= chain[AW];
  end

endmodule

// File: rtl/rsh_chk.sv
module rsh_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N-1:0]         din,
  input logic [$clog2(N)-1:0] amt,
  input logic [1:0]           mode,
  input logic [N-1:0]         dout
);
  // armed: the previous edge was taken out of reset
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R3
  zero_amt_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(amt) == '0) |-> (dout == $past(din)));

  // R5
  lsr_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(mode) == 2'b01 && $past(amt) != '0) |-> (dout[N-1] == 1'b0));

  // R6
  asr_sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(mode) == 2'b10) |-> (dout[N-1] == $past(din[N-1])));

  // R4 R7
  rot_ones_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && ($past(mode) == 2'b00 || $past(mode) == 2'b11))
      |-> ($countones(dout) == $countones($past(din))));

  // R8
  lsr_full_amt_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(mode) == 2'b01 && $past(amt) == N-1)
      |-> (dout[N-1:1] == '0 && dout[0] == $past(din[N-1])));

endmodule

bind log_shifter rsh_chk #(.N(N)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .din  (din),
  .amt  (amt),
  .mode (mode),
  .dout (dout)
);

// File: tb/log_shifter_bench.sv
module log_shifter_bench;
  localparam int N  = 8;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  din = '0;
  logic [AW-1:0] amt = '0;
  logic [1:0]    mode = 2'b00;
  logic [N-1:0]  dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  log_shifter #(.N(N)) u_log_shifter (
    .clk(clk), .rst(rst), .din(din), .amt(amt), .mode(mode), .dout(dout)
  );

  function automatic logic [N-1:0] ref_model(input logic [N-1:0] d,
                                             input int a, input logic [1:0] m);
    logic [2*N-1:0] dd;
    dd = {d, d} >> a;
    case (m)
      2'b01:   return d >> a;
      2'b10:   return $signed(d) >>> a;
      default: return dd[N-1:0];
    endcase
  endfunction

  function automatic string tag_of(input int a, input logic [1:0] m);
    if (a == 0)       return "R3/R2";
    if (a == N-1)     return (m == 2'b11) ? "R8/R7" : "R8";
    case (m)
      2'b00:   return "R4/R2";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] d, input int a, input logic [1:0] m,
                       input string tag);
    item_t it;
    @(negedge clk);
    din  = d;
    amt  = AW'(a);
    mode = m;
    it.exp = ref_model(d, a, m);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: result of inputs set at a negedge appears after the next posedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(dout, it.exp, it.tag);
      end
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset clears output
    din = 8'hA5;
    amt = 3'd2;
    repeat (3) @(posedge clk);
    #1 check(dout, '0, "R1");
    @(negedge clk) rst = 1'b0;

    // Directed cases
    drive(8'h80, 1, 2'b10, "R6");
    drive(8'h92, 3, 2'b10, "R6");
    drive(8'h80, 7, 2'b01, "R8");
    drive(8'h01, 1, 2'b00, "R4");
    drive(8'h01, 1, 2'b11, "R7");
    drive(8'h7F, 7, 2'b10, "R6/R8");
    drive(8'hC3, 0, 2'b10, "R3");

    // Exhaustive sweep
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < N; a++)
        for (int d = 0; d < (1 << N); d++)
          drive(N'(d), a, 2'(m), tag_of(a, 2'(m)));

    // Drain the scoreboard
    repeat (3) @(negedge clk);

    // R1: mid-run reset ignores inputs
    rst  = 1'b1;
    din  = 8'hFF;
    amt  = '0;
    mode = 2'b00;
    @(posedge clk);
    #1 check(dout, '0, "R1");

    done = 1'b1;
    finish_run();
  end

endmodule